// File: doc/BRIEF.md
# Configuration Frame ECC Checker

This block watches a stream of 32-bit words that together form one configuration frame. While the words go past, it builds an error-checking syndrome and an overall parity over the whole frame. One word at a fixed position in the frame does not carry payload. That word holds the check bits that were stored when the frame was written. When the last word has been accepted, the block reports whether the frame is clean, has one flipped bit, or has two flipped bits. For one flipped bit it also gives the word number and the bit number of that bit.

A frame starts on a word marked start-of-frame. A frame is cut short when an end marker arrives before the last word, or when a second start marker arrives before the frame has finished. Either case raises a one-cycle protocol error, the partial result is dropped, and no status is reported. A controller outside the block uses the status and the location to decide whether to repair one frame in place or to rewrite it in full.

Top module: `ecc_frame_checker`

## Requirements
- R1: A frame is WORDS accepted words, the first one marked by `in_sof`. `st_valid` pulses high for exactly one cycle. The pulse starts in the cycle after the clock edge that accepts word WORDS-1.
- R2: A frame whose bits all agree with its check word reports `st_code` = 0 (clean), with `err_word` = 0 and `err_bit` = 0.
- R3: The bits of a frame are coded as follows, with SW = clog2(WORDS*WIDTH+1)+1 (13 by default):
  - Payload bits are numbered in order, word-major and bit-minor, skipping the check word. Payload bit number n has the code 2^(SW-1) + n + 1.
  - In the check word (index CHK_IDX), bit k with k < SW has the code 2^k.
  - The remaining check-word bits below the top bit carry on the payload numbering after the last payload bit.
  - The top bit of the check word has the code 0.
  - A frame is consistent when the XOR of the codes of all set bits is zero and the frame holds an even number of ones.
- R4: A single flipped payload bit gives `st_code` = 1, with `err_word` and `err_bit` giving its position. When the status is not 1, both location outputs are 0.
- R5: A single flipped bit anywhere in the check word, including its top bit, gives `st_code` = 1 with `err_word` = CHK_IDX and `err_bit` set to that bit.
- R6: Two flipped bits in one frame, in any pair of positions, give `st_code` = 2 (double). Code 3 is never produced.
- R7: When `in_sof` is accepted while a frame is open, `proto_err` pulses for one cycle. No status is given for the open frame, and the marked word starts a new frame.
- R8: When `in_eof` is accepted on any word other than word WORDS-1, `proto_err` pulses for one cycle. The frame is dropped, no status follows, and the block waits for a new `in_sof`.
- R9: Words accepted with no frame open and no `in_sof` are ignored. Cycles with `in_valid` low inside a frame do not advance the word count.
- R10: While reset is held, and in the cycles after it until a frame completes, `st_valid`, `proto_err`, `st_code`, `err_word` and `err_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Word on `in_data` is accepted this cycle |
| in_sof | input | 1 | Accepted word is word 0 of a frame |
| in_eof | input | 1 | Accepted word is the last word of a frame |
| in_data | input | WIDTH | Frame word |
| st_valid | output | 1 | One-cycle status pulse |
| st_code | output | 2 | 0 clean, 1 single-bit error, 2 double-bit error |
| err_word | output | clog2(WORDS) | Word index of a single-bit error |
| err_bit | output | clog2(WIDTH) | Bit index of a single-bit error |
| proto_err | output | 1 | One-cycle pulse for a frame that was cut short |

## Verification
The bench builds the block with its default parameters: 101 words of 32 bits, with the check word at index 50. This size puts single flips within reach in several places:
- the first payload word and the last payload word;
- the words on each side of the check word;
- all three kinds of check-word bit: a syndrome bit, a spare coded bit, and the parity bit.

Every one of these paths runs through the decoder's mapping from syndrome back to position. Double flips are placed within one word, across the check word, and between payload and check bits. Frames with idle gaps, stray words, restarted frames and frames that end early show how the word counter behaves outside the normal run of words.

// File: rtl/ecc_frame_pkg.sv
package ecc_frame_pkg;

    typedef enum logic [1:0] {
        STAT_CLEAN  = 2'd0,
        STAT_SINGLE = 2'd1,
        STAT_DOUBLE = 2'd2
    } ecc_status_e;

endpackage

// File: rtl/frame_word_syn.sv
// Contribution of one word to the frame syndrome and to the overall parity.
module frame_word_syn #(
    parameter int WORDS   = 101,
    parameter int WIDTH   = 32,
    parameter int CHK_IDX = 50,
    parameter int CW      = 7,
    parameter int SW      = 13
) (
    input  logic [CW-1:0]    word_idx,
    input  logic [WIDTH-1:0] data,
    output logic [SW-1:0]    syn,
    output logic             par
);
    localparam logic [SW-1:0] TOPBIT   = SW'(1) << (SW-1);
    localparam logic [SW-1:0] WIDTH_S  = SW'(WIDTH);
    localparam logic [CW-1:0] CHK_W    = CW'(CHK_IDX);
    localparam int            RES_BASE = (WORDS-1)*WIDTH;

    logic            is_chk;
    logic [SW-1:0]   widx_ext;
    logic [SW-1:0]   base;
    logic [SW-1:0]   code [WIDTH];

    assign is_chk   = (word_idx == CHK_W);
    assign widx_ext = {{(SW-CW){1'b0}}, word_idx};
    assign base     = (word_idx < CHK_W) ? widx_ext * WIDTH_S
                                         : (widx_ext - SW'(1)) * WIDTH_S;

    for (genvar b = 0; b < WIDTH; b++) begin : g_code
        if (b < SW) begin : g_hamm
            assign code[b] = is_chk ? (SW'(1) << b) : (TOPBIT | (base + SW'(b + 1)));
        end else if (b == WIDTH-1) begin : g_parity
            assign code[b] = is_chk ? '0 : (TOPBIT | (base + SW'(b + 1)));
        end else begin : g_spare
            assign code[b] = is_chk ? (TOPBIT | SW'(RES_BASE + b - SW + 1))
                                    : (TOPBIT | (base + SW'(b + 1)));
        end
    end

    always_comb begin
        syn = '0;
        for (int b = 0; b < WIDTH; b++) begin
            if (data[b]) syn = syn ^ code[b];
        end
        par = ^data;
    end

endmodule

// File: rtl/frame_syn_decode.sv
// Maps the final syndrome and parity to a status and a bit location.
module frame_syn_decode
    import ecc_frame_pkg::*;
#(
    parameter int WORDS   = 101,
    parameter int WIDTH   = 32,
    parameter int CHK_IDX = 50,
    parameter int CW      = 7,
    parameter int BW      = 5,
    parameter int SW      = 13
) (
    input  logic [SW-1:0] syn,
    input  logic          par,
    output ecc_status_e   stat,
    output logic [CW-1:0] ew,
    output logic [BW-1:0] eb
);
    localparam int            PW      = SW - 1;
    localparam logic [PW-1:0] LIM_LO  = PW'(CHK_IDX*WIDTH);
    localparam logic [PW-1:0] LIM_PAY = PW'((WORDS-1)*WIDTH);
    localparam logic [PW-1:0] LIM_RES = PW'((WORDS-1)*WIDTH + WIDTH - 1 - SW);
    localparam logic [PW-1:0] WIDTH_P = PW'(WIDTH);
    localparam logic [PW-1:0] SW_P    = PW'(SW);
    localparam logic [CW-1:0] CHK_W   = CW'(CHK_IDX);

    logic          pow2;
    logic [BW-1:0] k;
    logic [PW-1:0] pos;

    always_comb begin
        pow2 = 1'b0;
        k    = '0;
        for (int i = 0; i < SW; i++) begin
            if (syn == (SW'(1) << i)) begin
                pow2 = 1'b1;
                k    = BW'(i);
            end
        end
        pos  = syn[PW-1:0] - PW'(1);
        stat = STAT_CLEAN;
        ew   = '0;
        eb   = '0;
        if (!par) begin
            if (syn != '0) stat = STAT_DOUBLE;
        end else if (syn == '0) begin
            stat = STAT_SINGLE;
            ew   = CHK_W;
            eb   = BW'(WIDTH-1);
        end else if (pow2) begin
            stat = STAT_SINGLE;
            ew   = CHK_W;
            eb   = k;
        end else if (syn[SW-1]) begin
            stat = STAT_SINGLE;
            if (pos < LIM_LO) begin
                ew = CW'(pos / WIDTH_P);
                eb = BW'(pos % WIDTH_P);
            end else if (pos < LIM_PAY) begin
                ew = CW'(pos / WIDTH_P) + CW'(1);
                eb = BW'(pos % WIDTH_P);
            end else if (pos < LIM_RES) begin
                ew = CHK_W;
                eb = BW'(pos - LIM_PAY + SW_P);
            end else begin
                stat = STAT_DOUBLE;
            end
        end else begin
            stat = STAT_DOUBLE;
        end
    end

endmodule

// File: rtl/ecc_frame_checker.sv
module ecc_frame_checker
    import ecc_frame_pkg::*;
#(
    parameter int WORDS   = 101,
    parameter int WIDTH   = 32,
    parameter int CHK_IDX = 50
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic                       in_eof,
    input  logic [WIDTH-1:0]           in_data,
    output logic                       st_valid,
    output logic [1:0]                 st_code,
    output logic [$clog2(WORDS)-1:0]   err_word,
    output logic [$clog2(WIDTH)-1:0]   err_bit,
    output logic                       proto_err
);
    localparam int            CW   = $clog2(WORDS);
    localparam int            BW   = $clog2(WIDTH);
    localparam int            SW   = $clog2(WORDS*WIDTH + 1) + 1;
    localparam logic [CW-1:0] LAST = CW'(WORDS-1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [SW-1:0] syn;
        logic          par;
        logic          st_valid;
        logic [1:0]    code;
        logic [CW-1:0] ew;
        logic [BW-1:0] eb;
        logic          proto;
    } state_t;

    state_t        st_d, st_q;
    logic [CW-1:0] widx;
    logic [SW-1:0] wsyn;
    logic          wpar;
    ecc_status_e   dec_stat;
    logic [CW-1:0] dec_ew;
    logic [BW-1:0] dec_eb;

    assign widx = in_sof ? '0 : st_q.cnt;

    frame_word_syn #(
        .WORDS(WORDS), .WIDTH(WIDTH), .CHK_IDX(CHK_IDX), .CW(CW), .SW(SW)
    ) u_word_syn (
        .word_idx (widx),
        .data     (in_data),
        .syn      (wsyn),
        .par      (wpar)
    );

    frame_syn_decode #(
        .WORDS(WORDS), .WIDTH(WIDTH), .CHK_IDX(CHK_IDX), .CW(CW), .BW(BW), .SW(SW)
    ) u_decode (
        .syn  (st_q.syn ^ wsyn),
        .par  (st_q.par ^ wpar),
        .stat (dec_stat),
        .ew   (dec_ew),
        .eb   (dec_eb)
    );

    always_comb begin
        st_d          = st_q;
        st_d.st_valid = 1'b0;
        st_d.proto    = 1'b0;
        st_d.code     = STAT_CLEAN;
        st_d.ew       = '0;
        st_d.eb       = '0;
        if (in_valid) begin
            if (in_sof) begin
                st_d.proto = st_q.busy || in_eof;
                st_d.busy  = !in_eof;
                st_d.cnt   = in_eof ? '0 : CW'(1);
                st_d.syn   = wsyn;
                st_d.par   = wpar;
            end else if (st_q.busy) begin
                if (st_q.cnt == LAST) begin
                    st_d.busy     = 1'b0;
                    st_d.cnt      = '0;
                    st_d.st_valid = 1'b1;
                    st_d.code     = dec_stat;
                    st_d.ew       = dec_ew;
                    st_d.eb       = dec_eb;
                end else if (in_eof) begin
                    st_d.proto = 1'b1;
                    st_d.busy  = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                    st_d.syn = st_q.syn ^ wsyn;
                    st_d.par = st_q.par ^ wpar;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_valid  = st_q.st_valid;
    assign st_code   = st_q.code;
    assign err_word  = st_q.ew;
    assign err_bit   = st_q.eb;
    assign proto_err = st_q.proto;

    assert_status_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);
    assert_status_after_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> $past(in_valid));
    assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_code != 2'b11));
    assert_loc_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_code != 2'd1) |-> (err_word == '0 && err_bit == '0));
    assert_loc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_code == 2'd1) |-> (err_word <= LAST));
    assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && proto_err));

endmodule

// File: tb/ecc_frame_checker_tb_top.sv
`timescale 1ns/1ps
module ecc_frame_checker_tb_top;
    localparam int WORDS = 101;
    localparam int WIDTH = 32;
    localparam int CHK   = 50;
    localparam int SW    = 13;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             st_valid, proto_err;
    logic [1:0]       st_code;
    logic [6:0]       err_word;
    logic [4:0]       err_bit;

    int checks = 0, failures = 0;
    int nvalid = 0, nproto = 0;
    int last_code = -1, last_w = -1, last_b = -1;
    logic [WIDTH-1:0] fr [WORDS];

    always #5 clk = ~clk;

    ecc_frame_checker #(.WORDS(WORDS), .WIDTH(WIDTH), .CHK_IDX(CHK)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_data(in_data), .st_valid(st_valid), .st_code(st_code), .err_word(err_word),
        .err_bit(err_bit), .proto_err(proto_err));

    always @(negedge clk) begin
        if (st_valid) begin
            nvalid++;
            last_code = int'(st_code);
            last_w    = int'(err_word);
            last_b    = int'(err_bit);
        end
        if (proto_err) nproto++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Code of each bit as laid down in R3.
    function automatic int code_of(int w, int b);
        if (w == CHK) begin
            if (b < SW) return 1 << b;
            if (b == WIDTH-1) return 0;
            return (1 << (SW-1)) | ((WORDS-1)*WIDTH + b - SW + 1);
        end
        return (1 << (SW-1)) | (((w < CHK) ? w : w-1)*WIDTH + b + 1);
    endfunction

    task automatic build_frame();
        int syn = 0;
        logic p = 1'b0;
        for (int w = 0; w < WORDS; w++) fr[w] = $urandom;
        fr[CHK][SW-1:0]  = '0;
        fr[CHK][WIDTH-1] = 1'b0;
        for (int w = 0; w < WORDS; w++)
            for (int b = 0; b < WIDTH; b++)
                if (fr[w][b]) syn = syn ^ code_of(w, b);
        fr[CHK][SW-1:0] = syn[SW-1:0];
        for (int w = 0; w < WORDS; w++) p = p ^ (^fr[w]);
        fr[CHK][WIDTH-1] = p;
    endtask

    task automatic send(int nwords, int eof_at, int gap);
        for (int w = 0; w < nwords; w++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (w == 0);
            in_eof   = (w == eof_at);
            in_data  = fr[w];
            if (gap > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_data  = ~fr[w];
                repeat (gap-1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic expect_status(string req, int code, int w, int b, int v0);
        settle();
        check({req, " status count"}, nvalid, v0 + 1);
        check({req, " code"}, last_code, code);
        check({req, " word"}, last_w, w);
        check({req, " bit"}, last_b, b);
    endtask

    task automatic t_reset();
        #1;
        check("R10 st_valid in reset", int'(st_valid), 0);
        check("R10 proto_err in reset", int'(proto_err), 0);
        rst_n = 1'b1;
        settle();
        check("R10 code after reset", int'(st_code), 0);
        check("R10 location after reset", int'(err_word) + int'(err_bit), 0);
        check("R10 no pulses", nvalid + nproto, 0);
    endtask

    task automatic t_clean(int gap);
        int v0 = nvalid;
        build_frame();
        send(WORDS, WORDS-1, gap);
        expect_status("R2 R3 R1 clean", 0, 0, 0, v0);
    endtask

    task automatic t_single(int w, int b, string req);
        int v0 = nvalid;
        build_frame();
        fr[w][b] = ~fr[w][b];
        send(WORDS, WORDS-1, 0);
        expect_status(req, 1, w, b, v0);
    endtask

    task automatic t_double(int w1, int b1, int w2, int b2);
        int v0 = nvalid;
        build_frame();
        fr[w1][b1] = ~fr[w1][b1];
        fr[w2][b2] = ~fr[w2][b2];
        send(WORDS, WORDS-1, 0);
        expect_status("R6 double", 2, 0, 0, v0);
    endtask

    task automatic t_restart();
        int v0 = nvalid, p0 = nproto;
        build_frame();
        send(40, -1, 0);
        send(WORDS, WORDS-1, 0);
        settle();
        check("R7 proto pulse on restart", nproto, p0 + 1);
        check("R7 one status for new frame", nvalid, v0 + 1);
        check("R7 new frame clean", last_code, 0);
    endtask

    task automatic t_early_eof();
        int v0 = nvalid, p0 = nproto;
        build_frame();
        send(30, 29, 0);
        repeat (120) @(negedge clk);
        settle();
        check("R8 proto pulse on early end", nproto, p0 + 1);
        check("R8 no status after early end", nvalid, v0);
        send(WORDS, WORDS-1, 0);
        settle();
        check("R8 idle after drop, no extra proto", nproto, p0 + 1);
        check("R8 next frame reported", nvalid, v0 + 1);
    endtask

    task automatic t_stray();
        int v0 = nvalid, p0 = nproto;
        for (int i = 0; i < 2*WORDS; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i % 7 == 0);
            in_data = $urandom;
        end
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        settle();
        check("R9 stray words give no status", nvalid, v0);
        check("R9 stray words give no proto", nproto, p0);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_clean(0);
        t_clean(2);                 // R9 gaps inside a frame
        t_single(0, 0, "R4 first word");
        t_single(WORDS-1, WIDTH-1, "R4 last word");
        t_single(CHK-1, 17, "R4 below check word");
        t_single(CHK+1, 3, "R4 above check word");
        t_single(CHK, 5, "R5 check syndrome bit");
        t_single(CHK, 20, "R5 check spare bit");
        t_single(CHK, WIDTH-1, "R5 check parity bit");
        t_double(7, 2, 7, 30);
        t_double(10, 4, 90, 4);
        t_double(CHK, 0, 33, 12);
        t_restart();
        t_early_eof();
        t_stray();
        t_clean(0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule